// File: doc/BRIEF.md
# Chained Store Write Issuer

This block sits between a store pipeline and a pipelined Wishbone master port. Each store it accepts becomes one write beat on the bus. The first store opens a bus cycle. Later stores that target the same page are folded into that cycle as further beats, so a burst of nearby stores costs one arbitration instead of many. The cycle stays open while eligible stores keep arriving and acknowledgements are still due.

The store side is a valid/ready stream. A request is held (valid high, payload stable) until `in_ready` is seen high on a rising edge. `in_ready` is computed from the engine state and the payload of the waiting request, never from `in_valid`. When the bus is idle, `in_ready` is always high.

A quadword store travels as two doubleword requests. Its two halves go out inside one unbroken bus cycle, so no other master can write between them. A store-conditional normally needs a cycle of its own. The only exception is the second half of a quadword whose first half has already gone out. The block pulses `done` for every accepted request, and pulses `cache_we` when the bus takes a beat whose request hit the cache.

Top module: `wb_store_issue`

## Requirements
- R1: After reset, `wb_cyc`, `wb_stb`, `done` and `cache_we` are low, and `in_ready` is high.
- R2: A request accepted while the bus is idle raises `wb_cyc`, `wb_we` and `wb_stb` on the next cycle. `wb_adr`, `wb_dat` and `wb_sel` then carry that request's address, data and byte lanes.
- R3: While `wb_stb` is high and `wb_stall` is high, `wb_stb`, `wb_adr`, `wb_dat` and `wb_sel` hold their values into the next cycle.
- R4: With the cycle open, a request is chained as the next beat in the cycle after the handshake. Chaining requires all of the following:
  - the address bits from `PAGE_BITS` upward equal those of the beat that opened or last joined the cycle;
  - `in_zero` is low;
  - no beat is held by stall.
- R5: A request that cannot be chained waits with `in_ready` low. It is accepted only once the open cycle has closed.
- R6: No more than `MAX_OUT` (7) beats are ever accepted by the bus and still unacknowledged. A chained request waits while the count, after this cycle's accept and ack, would reach `MAX_OUT`.
- R7: `wb_cyc` falls only under all of the following conditions:
  - no strobe is pending;
  - no request is being taken;
  - the atomic flag is clear;
  - either nothing is outstanding, or the single outstanding ack arrives in that cycle.
- R8: A store-conditional (`in_cond`=1) is chained only when all of these hold:
  - it is the second half of a quadword (`in_qw`=1, `in_first`=0);
  - the atomic flag is set;
  - the other R4 conditions hold.
- R9: Each accepted request sets the atomic flag to the inverse of its effective last flag. While the flag is set, `wb_cyc` stays high. A valid request that is not eligible for chaining (R4 or R8) clears the flag.
- R10: For requests with `in_qw`=0, the first and last flags are taken as 1. Such a store-conditional is never chained, and such a request never sets the atomic flag.
- R11: `done` pulses for one cycle after each request handshake. `cache_we` pulses for one cycle after the bus accepts a beat (stb high, stall low) whose request had `in_hit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Store request valid |
| in_ready | output | 1 | Store request accepted this edge when high with valid |
| in_addr | input | AW | Byte address of the store |
| in_data | input | DW | Store data |
| in_sel | input | DW/8 | Byte lane enables |
| in_qw | input | 1 | Request is one half of a quadword store |
| in_first | input | 1 | First doubleword of a quadword |
| in_last | input | 1 | Last doubleword of a quadword |
| in_cond | input | 1 | Store-conditional |
| in_zero | input | 1 | Cache-zeroing store |
| in_hit | input | 1 | Store hits the cache |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Bus address |
| wb_dat | output | DW | Bus write data |
| wb_sel | output | DW/8 | Bus byte select |
| wb_stall | input | 1 | Slave stall |
| wb_ack | input | 1 | Slave acknowledge |
| done | output | 1 | Completion pulse per accepted request |
| cache_we | output | 1 | Cache data write pulse per accepted hit beat |

## Verification
The hardest situation to reach from the ports is a full set of seven unacknowledged beats, with a further same-page request pressing against the limit while acks trickle back. A dedicated phase holds `in_valid` high with same-page, non-conditional stores, removes stall, and gives the slave model ack latencies of ten cycles or more, so that the count climbs to the bound before the first ack returns. Other phases mix quadword pairs, store-conditionals, page changes and zeroing stores under heavy random stall. This exercises the atomic hold and its clearing while acks are still in flight.

// File: rtl/sis_pkg.sv
`timescale 1ns/1ps
package sis_pkg;
  // Effective first/last doubleword flag: single-beat requests count as both.
  function automatic logic dw_flag(input logic is_qw, input logic flag);
    return !is_qw || flag;
  endfunction
endpackage

// File: rtl/sis_ack_tracker.sv
`timescale 1ns/1ps
module sis_ack_tracker #(
  parameter int MAX_OUT = 7,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             room
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (accept && !ack)      cnt_nxt = cnt_q + 1'b1;
    else if (!accept && ack) cnt_nxt = cnt_q - 1'b1;
  end

  // Another beat may be queued only if the post-edge count leaves space.
  assign room = (int'(cnt_nxt) < MAX_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sis_chain_judge.sv
`timescale 1ns/1ps
module sis_chain_judge #(
  parameter int AW = 32,
  parameter int PAGE_BITS = 12,
  localparam int PW = AW - PAGE_BITS
) (
  input  logic [AW-1:0] in_addr,
  input  logic          in_qw,
  input  logic          in_first,
  input  logic          in_cond,
  input  logic          in_zero,
  input  logic [PW-1:0] page_q,
  input  logic          amore_q,
  output logic          eligible
);
  import sis_pkg::*;
  logic same_page, cond_ok;

  assign same_page = (in_addr[AW-1:PAGE_BITS] == page_q);
  // A conditional store joins only as the trailing half of a pair in flight.
  assign cond_ok   = !in_cond || (amore_q && !dw_flag(in_qw, in_first));
  assign eligible  = same_page && !in_zero && cond_ok;
endmodule

// File: rtl/wb_store_issue.sv
`timescale 1ns/1ps
module wb_store_issue #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int PAGE_BITS = 12,
  parameter int MAX_OUT = 7,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [SW-1:0] in_sel,
  input  logic          in_qw,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_cond,
  input  logic          in_zero,
  input  logic          in_hit,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat,
  output logic [SW-1:0] wb_sel,
  input  logic          wb_stall,
  input  logic          wb_ack,
  output logic          done,
  output logic          cache_we
);
  import sis_pkg::*;
  localparam int PW    = AW - PAGE_BITS;
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic          cyc_q, stb_q, amore_q, hit_q, done_q, cwe_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;
  logic [SW-1:0] sel_q;
  logic [PW-1:0] page_q;
  logic [CNT_W-1:0] cnt_q;
  logic room, eligible, accept, slot_free, take, close_now;

  assign accept    = stb_q && !wb_stall;
  assign slot_free = !stb_q || !wb_stall;

  sis_ack_tracker #(.MAX_OUT(MAX_OUT)) u_ack (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ack(wb_ack),
    .cnt_q(cnt_q), .room(room)
  );

  sis_chain_judge #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_judge (
    .in_addr(in_addr), .in_qw(in_qw), .in_first(in_first), .in_cond(in_cond),
    .in_zero(in_zero), .page_q(page_q), .amore_q(amore_q), .eligible(eligible)
  );

  assign in_ready  = !cyc_q || (eligible && slot_free && room);
  assign take      = in_valid && in_ready;
  assign close_now = cyc_q && !stb_q && !take && !amore_q &&
                     ((cnt_q == '0) || ((cnt_q == CNT_W'(1)) && wb_ack));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= 1'b0;
      stb_q   <= 1'b0;
      amore_q <= 1'b0;
      hit_q   <= 1'b0;
      done_q  <= 1'b0;
      cwe_q   <= 1'b0;
      adr_q   <= '0;
      dat_q   <= '0;
      sel_q   <= '0;
      page_q  <= '0;
    end else begin
      done_q <= take;
      cwe_q  <= accept && hit_q;
      if (take) begin
        cyc_q   <= 1'b1;
        stb_q   <= 1'b1;
        adr_q   <= in_addr;
        dat_q   <= in_data;
        sel_q   <= in_sel;
        hit_q   <= in_hit;
        page_q  <= in_addr[AW-1:PAGE_BITS];
        amore_q <= !dw_flag(in_qw, in_last);
      end else begin
        if (accept)    stb_q <= 1'b0;
        if (close_now) cyc_q <= 1'b0;
        if (cyc_q && in_valid && !eligible) amore_q <= 1'b0;
      end
    end
  end

  assign wb_cyc   = cyc_q;
  assign wb_stb   = stb_q;
  assign wb_we    = cyc_q;
  assign wb_adr   = adr_q;
  assign wb_dat   = dat_q;
  assign wb_sel   = sel_q;
  assign done     = done_q;
  assign cache_we = cwe_q;
endmodule

// File: rtl/wb_store_issue_chk.sv
`timescale 1ns/1ps
module wb_store_issue_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int MAX_OUT = 7,
  localparam int SW = DW / 8,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wb_cyc,
  input logic             wb_stb,
  input logic             wb_stall,
  input logic             wb_ack,
  input logic [AW-1:0]    wb_adr,
  input logic [DW-1:0]    wb_dat,
  input logic [SW-1:0]    wb_sel,
  input logic             done,
  input logic             cache_we,
  input logic [CNT_W-1:0] cnt_q,
  input logic             amore_q
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && wb_stall |=> wb_stb && $stable(wb_adr) && $stable(wb_dat) && $stable(wb_sel));
  // R2
  stb_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_cyc |-> in_ready);
  // R7
  no_early_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && (cnt_q > CNT_W'(1)) |=> wb_cyc);
  // R9
  atomic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && amore_q && !in_valid |=> wb_cyc);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && (int'(cnt_q) == MAX_OUT) && !wb_ack |-> !(in_valid && in_ready));
  // R11
  cwe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> $past(wb_stb && !wb_stall));
  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready));
endmodule

bind wb_store_issue wb_store_issue_chk #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_stall(wb_stall), .wb_ack(wb_ack),
  .wb_adr(wb_adr), .wb_dat(wb_dat), .wb_sel(wb_sel), .done(done),
  .cache_we(cache_we), .cnt_q(cnt_q), .amore_q(amore_q)
);

// File: tb/wb_store_issue_tb.sv
`timescale 1ns/1ps
module wb_store_issue_tb;
  localparam int AW = 32, DW = 64, SW = 8, PB = 12, MAXO = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_qw = 0, in_first = 0, in_last = 0, in_cond = 0, in_zero = 0, in_hit = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_sel = '0;
  logic wb_stall = 0, wb_ack = 0;
  logic in_ready, wb_cyc, wb_stb, wb_we, done, cache_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat;
  logic [SW-1:0] wb_sel;

  wb_store_issue #(.AW(AW), .DW(DW), .PAGE_BITS(PB), .MAX_OUT(MAXO)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_sel(in_sel), .in_qw(in_qw),
    .in_first(in_first), .in_last(in_last), .in_cond(in_cond), .in_zero(in_zero),
    .in_hit(in_hit), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat(wb_dat), .wb_sel(wb_sel), .wb_stall(wb_stall),
    .wb_ack(wb_ack), .done(done), .cache_we(cache_we)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_cyc, m_stb, m_amore, m_hit, m_done, m_cwe;
  logic [AW-1:0] m_adr;
  logic [DW-1:0] m_dat;
  logic [SW-1:0] m_sel;
  logic [AW-PB-1:0] m_page;
  int m_cnt;

  function automatic bit m_elig();
    return (in_addr[AW-1:PB] == m_page) && !in_zero &&
           (!in_cond || (m_amore && in_qw && !in_first));
  endfunction

  function automatic bit m_ready();
    int nx;
    nx = m_cnt + ((m_stb && !wb_stall) ? 1 : 0) - (wb_ack ? 1 : 0);
    return !m_cyc || (m_elig() && (!m_stb || !wb_stall) && nx < MAXO);
  endfunction

  always @(posedge clk) begin
    bit tk, acc, cl, el;
    if (!rst_n) begin
      m_cyc = 0; m_stb = 0; m_amore = 0; m_hit = 0; m_done = 0; m_cwe = 0;
      m_adr = '0; m_dat = '0; m_sel = '0; m_page = '0; m_cnt = 0;
    end else begin
      acc = m_stb && !wb_stall;
      tk  = in_valid && m_ready();
      el  = m_elig();
      cl  = m_cyc && !m_stb && !tk && !m_amore && (m_cnt == 0 || (m_cnt == 1 && wb_ack));
      m_cnt  = m_cnt + (acc ? 1 : 0) - (wb_ack ? 1 : 0);
      m_done = tk;
      m_cwe  = acc && m_hit;
      if (tk) begin
        m_cyc = 1; m_stb = 1; m_adr = in_addr; m_dat = in_data; m_sel = in_sel;
        m_hit = in_hit; m_page = in_addr[AW-1:PB];
        m_amore = in_qw && !in_last;
      end else begin
        if (m_cyc && in_valid && !el) m_amore = 0;
        if (acc) m_stb = 0;
        if (cl) m_cyc = 0;
      end
    end
  end

  // ---------------- stimulus and slave ----------------
  int q[$];
  int outs = 0, max_outs = 0, last_rdy = 0, pairs = 0;
  bit taken = 0, need_second = 0, pair_cond = 0, pend = 0, hold_chk = 0;
  logic [AW-PB-1:0] cur_page = '0;
  logic [AW-1:0] hold_adr;
  int stall_pct, lat_lo, lat_hi, v_pct, z_pct, c_pct, qw_pct, pg_pct;

  task automatic gen_req();
    if (need_second) begin
      in_valid = 1; in_qw = 1; in_first = 0; in_last = 1; in_cond = pair_cond; in_zero = 0;
      in_addr = {cur_page, PB'($urandom_range(511) * 8)};
      in_data = {$urandom, $urandom}; in_sel = 8'hFF; in_hit = 1'($urandom_range(1));
      need_second = 0;
    end else if ($urandom_range(99) < v_pct) begin
      if ($urandom_range(99) < pg_pct) cur_page = cur_page ^ 1;
      in_valid = 1;
      in_cond  = ($urandom_range(99) < c_pct);
      in_qw    = ($urandom_range(99) < qw_pct);
      in_zero  = !in_qw && ($urandom_range(99) < z_pct);
      if (in_qw) begin
        in_first = 1; in_last = 0; need_second = 1; pair_cond = in_cond;
      end else begin
        in_first = 1'($urandom_range(1)); in_last = 1'($urandom_range(1));
      end
      in_addr = {cur_page, PB'($urandom_range(511) * 8)};
      in_data = {$urandom, $urandom};
      in_sel  = 8'($urandom_range(255));
      in_hit  = 1'($urandom_range(1));
    end else begin
      in_valid = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wb_cyc == 0, "R1 cyc after reset", wb_cyc, 0);
    chk(wb_stb == 0, "R1 stb after reset", wb_stb, 0);
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    chk(done == 0 && cache_we == 0, "R1 pulses after reset", {done, cache_we}, 0);

    for (int n = 0; n < 3500; n++) begin
      @(negedge clk);
      chk(wb_cyc == m_cyc, "R7 cyc", wb_cyc, m_cyc);
      chk(wb_stb == m_stb, "R4 stb", wb_stb, m_stb);
      chk(wb_we == m_cyc, "R2 we", wb_we, m_cyc);
      chk(wb_adr == m_adr, "R2 adr", wb_adr, m_adr);
      chk(wb_dat == m_dat, "R2 dat", wb_dat, m_dat);
      chk(wb_sel == m_sel, "R2 sel", wb_sel, m_sel);
      chk(done == m_done, "R11 done", done, m_done);
      chk(cache_we == m_cwe, "R11 cache_we", cache_we, m_cwe);
      if (hold_chk) chk(wb_stb && wb_adr == hold_adr, "R3 beat held under stall", wb_adr, hold_adr);
      if (pend) chk(wb_cyc == 1, "R9 cycle held between quadword halves", wb_cyc, 1);

      if (n < 1000)      begin stall_pct = 0;  lat_lo = 0;  lat_hi = 1;  v_pct = 85;  z_pct = 8; c_pct = 12; qw_pct = 15; pg_pct = 20; end
      else if (n < 2000) begin stall_pct = 45; lat_lo = 0;  lat_hi = 4;  v_pct = 85;  z_pct = 8; c_pct = 12; qw_pct = 15; pg_pct = 20; end
      else if (n < 2600) begin stall_pct = 0;  lat_lo = 10; lat_hi = 14; v_pct = 100; z_pct = 0; c_pct = 0;  qw_pct = 0;  pg_pct = 0;  end
      else               begin stall_pct = 20; lat_lo = 2;  lat_hi = 6;  v_pct = 90;  z_pct = 5; c_pct = 20; qw_pct = 25; pg_pct = 15; end

      // slave: one ack per cycle, never in the same cycle the beat is accepted
      if (q.size() > 0 && q[0] <= n) begin
        wb_ack = 1; void'(q.pop_front()); outs--;
      end else wb_ack = 0;
      wb_stall = ($urandom_range(99) < stall_pct);
      hold_chk = wb_stb && wb_stall;
      hold_adr = wb_adr;
      if (wb_stb && !wb_stall) begin
        int r;
        r = n + 1 + $urandom_range(lat_hi - lat_lo) + lat_lo;
        if (r < last_rdy) r = last_rdy;
        last_rdy = r;
        q.push_back(r);
        outs++;
      end
      if (outs > max_outs) max_outs = outs;
      chk(outs <= MAXO, "R6 outstanding bound", outs, MAXO);

      if (taken) in_valid = 0;
      if (!in_valid) gen_req();
      #1;
      chk(in_ready == m_ready(), "R4 R5 R6 R8 R10 ready", in_ready, m_ready());
      taken = in_valid && in_ready;
      if (taken) begin
        if (in_cond && wb_cyc) begin
          if (!in_qw) chk(1'b0, "R10 single store-conditional chained", 1, 0);
          else        chk(!in_first, "R8 store-conditional chained as first half", in_first, 0);
        end
        pend = in_qw && !in_last;
        if (pend) pairs++;
      end
    end
    chk(max_outs == MAXO, "R6 bound reached", max_outs, MAXO);
    chk(pairs > 0, "R9 quadword pairs issued", pairs, 1);
    finish_up();
  end
endmodule